// File: doc/BRIEF.md
# Multiplexed LCD Row Scanner

This block sequences the rows of a multiplexed liquid-crystal panel and decides, for each of its 60 driver pins, which of four analog drive levels that pin should select. A row counter steps through 2, 4 or 8 rows. At each row boundary the display word for the row that is starting is copied from an external display memory into a display latch. That latch then supplies the on/off state of every column pin for the whole row. The drive polarity is reversed from one frame to the next, so that on average the panel sees no DC component.

In row-and-column mode the block times itself from a system-clock divider. Its first n pins act as row drivers and the rest act as columns. It drives the frame polarity out so that cascaded parts can follow it. In column-only mode every pin is a column. Polarity and frame alignment are then taken from an external frame input: each transition of that input restarts the row sequence. Blank and set controls override all column pins without changing memory. A resynchronisation pulse restarts the scan at the first row. The analog bias network and the output buffers are outside this block; it produces only 2-bit level-select codes.

Top module: `lcd_row_scanner`

## Requirements
- R1: The row counter advances exactly once every ROW_DIV clock cycles and visits rows 0,1,…,n-1 and then 0 again. The value of n is 2 for mux_sel=00, 4 for mux_sel=01 and 8 for mux_sel=10 or 11.
- R2: In row-and-column mode (col_only=0), pin k for k<n is a row driver. The pin for the current row carries the select code and the other row pins carry the non-select code. Pin k for k≥n is a column pin showing bit k-n of the display latch.
- R3: In column-only mode (col_only=1), all 60 pins are column pins and pin k shows latch bit k, whatever the value of mux_sel.
- R4: Pin k uses drv_code[2k+1:2k]. The codes are 00 for the low rail, 01 for the lower middle level, 10 for the upper middle level and 11 for the high rail. With polarity 0, a selected row is 11, an unselected row is 01, an on column is 00 and an off column is 10. With polarity 1, each of these is mirrored: 00, 10, 11 and 01 respectively.
- R5: In row-and-column mode the polarity toggles in the same cycle that the row counter wraps to row 0. frame_out always shows the polarity.
- R6: In column-only mode the polarity changes only when ext_frame_in changes. On such a change the block takes the new ext_frame_in value as its polarity and restarts at row 0 with a fresh divider count. A wrap of the row counter does not change the polarity.
- R7: While blank=1, every column pin carries the off code. When set_all=1 and blank=0, every column pin carries the on code. Blank wins when both are high. Row pins and the stored data are unaffected, so normal data returns once both are released.
- R8: A sync_req pulse moves the scan to row 0 on the next clock edge, restarts the row divider and keeps the current polarity.
- R9: mem_addr names the row whose word will be loaded next. The latch samples mem_data only at a row boundary or at a restart, so changes to memory during a row do not affect the outputs.
- R10: After reset the row is 0, the polarity is 0 and the latch is cleared, so every column pin is off. mem_addr then points at row 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_sel | input | 2 | Row count select: 00→2, 01→4, 1x→8 |
| col_only | input | 1 | 1 = all pins are columns, timing follows ext_frame_in |
| blank | input | 1 | Force all column pins off |
| set_all | input | 1 | Force all column pins on |
| sync_req | input | 1 | Restart the scan at row 0 |
| ext_frame_in | input | 1 | External frame polarity used in column-only mode |
| mem_data | input | NUM_OUT | Display word for the row addressed by mem_addr |
| mem_addr | output | 3 | Row whose word is loaded next |
| row_sel | output | 3 | Currently active row |
| frame_out | output | 1 | Current frame polarity |
| drv_code | output | 2*NUM_OUT | Level-select code, two bits per pin |

## Verification
The scan is exercised with 8, 4 and 2 rows in row-and-column mode, each over at least two frames. These runs show the row order, the row period and the split between row and column pins for each ratio, and that the polarity flips only at the wrap. Column-only mode is run with 4 and 8 rows. Those runs separate the external frame restart from the internal wrap, which must leave the polarity alone, and show that every pin becomes a column. Distinct words per row expose any misalignment between the latch and the row counter. Blank, set, both together, a memory change during a row, and a resync in the middle of a frame are each checked at the outputs.

// File: rtl/lcd_row_scanner.sv
module lcd_row_scanner #(
  parameter int NUM_OUT = 60,
  parameter int ROW_DIV = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mux_sel,
  input  logic                 col_only,
  input  logic                 blank,
  input  logic                 set_all,
  input  logic                 sync_req,
  input  logic                 ext_frame_in,
  input  logic [NUM_OUT-1:0]   mem_data,
  output logic [2:0]           mem_addr,
  output logic [2:0]           row_sel,
  output logic                 frame_out,
  output logic [2*NUM_OUT-1:0] drv_code
);
  localparam int MAX_ROWS = 8;
  localparam int RW = $clog2(MAX_ROWS);
  localparam int DW = (ROW_DIV > 2) ? $clog2(ROW_DIV) : 1;
  localparam logic [1:0] LV_LO  = 2'b00;
  localparam logic [1:0] LV_MLO = 2'b01;
  localparam logic [1:0] LV_MHI = 2'b10;
  localparam logic [1:0] LV_HI  = 2'b11;

  logic [DW-1:0]      cnt;
  logic [RW-1:0]      row;
  logic               pol;
  logic               ext_q;
  logic [NUM_OUT-1:0] latch;

  logic [3:0]    n_rows;
  logic [RW-1:0] last_row;
  logic          tick, ext_edge, restart, wrap;
  logic [RW-1:0] nxt_row;

  assign n_rows   = (mux_sel == 2'b00) ? 4'd2 : (mux_sel == 2'b01) ? 4'd4 : 4'd8;
  assign last_row = RW'(n_rows - 4'd1);
  assign tick     = (cnt == DW'(ROW_DIV - 1));
  assign ext_edge = col_only && (ext_frame_in != ext_q);
  assign restart  = sync_req || ext_edge;
  assign wrap     = (row >= last_row);
  assign nxt_row  = wrap ? '0 : row + 1'b1;
  assign mem_addr = restart ? '0 : nxt_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      row   <= '0;
      pol   <= 1'b0;
      ext_q <= 1'b0;
      latch <= '0;
    end else begin
      ext_q <= ext_frame_in;
      if (restart) begin
        cnt   <= '0;
        row   <= '0;
        latch <= mem_data;
        if (ext_edge) pol <= ext_frame_in;
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          row   <= nxt_row;
          latch <= mem_data;
          if (wrap && !col_only) pol <= ~pol;
        end
      end
    end
  end

  assign row_sel   = row;
  assign frame_out = pol;

  logic [1:0] c_sel, c_unsel, c_on, c_off;
  assign c_sel   = pol ? LV_LO  : LV_HI;
  assign c_unsel = pol ? LV_MHI : LV_MLO;
  assign c_on    = pol ? LV_HI  : LV_LO;
  assign c_off   = pol ? LV_MLO : LV_MHI;

  logic [NUM_OUT-1:0] col_vec;
  assign col_vec = col_only ? latch : (latch << n_rows);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_pin
    logic row_pin, row_hit, col_on;
    if (k < MAX_ROWS) begin : g_row
      assign row_pin = !col_only && (4'(k) < n_rows);
      assign row_hit = (row == RW'(k));
    end else begin : g_col
      assign row_pin = 1'b0;
      assign row_hit = 1'b0;
    end
    assign col_on = !blank && (set_all || col_vec[k]);
    assign drv_code[2*k +: 2] = row_pin ? (row_hit ? c_sel : c_unsel)
                                        : (col_on ? c_on : c_off);
  end
endmodule

// File: rtl/lcd_row_scanner_chk.sv
module lcd_row_scanner_chk #(
  parameter int NUM_OUT = 60
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mux_sel,
  input logic                 col_only,
  input logic                 blank,
  input logic                 set_all,
  input logic                 sync_req,
  input logic                 ext_frame_in,
  input logic [2:0]           row_sel,
  input logic                 frame_out,
  input logic [2*NUM_OUT-1:0] drv_code,
  input logic                 tick,
  input logic                 restart
);
  logic [3:0] n;
  logic [7:0] sel_f;
  logic       cols_off, cols_on;

  assign n = (mux_sel == 2'b00) ? 4'd2 : (mux_sel == 2'b01) ? 4'd4 : 4'd8;

  always_comb begin
    sel_f    = '0;
    cols_off = 1'b1;
    cols_on  = 1'b1;
    for (int k = 0; k < NUM_OUT; k++) begin
      if (!col_only && k < int'(n)) begin
        sel_f[3'(k)] = (drv_code[2*k +: 2] == (frame_out ? 2'b00 : 2'b11));
      end else begin
        if (drv_code[2*k +: 2] != (frame_out ? 2'b01 : 2'b10)) cols_off = 1'b0;
        if (drv_code[2*k +: 2] != (frame_out ? 2'b11 : 2'b00)) cols_on  = 1'b0;
      end
    end
  end

  a_r1_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(row_sel) && !$past(restart)) |->
      ($past(tick) && (row_sel == 3'd0 || row_sel == $past(row_sel) + 3'd1)));

  a_r2_single_row_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_only && ({1'b0, row_sel} < n)) |-> ($countones(sel_f) == 1 && sel_f[row_sel]));

  a_r5_toggle_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(col_only) && !$stable(frame_out)) |-> (row_sel == 3'd0 && $past(tick)));

  a_r6_follow_ext_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(col_only) && !$stable(frame_out)) |-> (frame_out == $past(ext_frame_in) && row_sel == 3'd0));

  a_r7_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> cols_off);

  a_r7_set_on: assert property (@(posedge clk) disable iff (!rst_n)
    (set_all && !blank) |-> cols_on);

  a_r8_sync_to_first_row: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_req) |-> (row_sel == 3'd0 && $stable(frame_out)));
endmodule

bind lcd_row_scanner lcd_row_scanner_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .col_only(col_only),
  .blank(blank), .set_all(set_all), .sync_req(sync_req),
  .ext_frame_in(ext_frame_in), .row_sel(row_sel), .frame_out(frame_out),
  .drv_code(drv_code), .tick(tick), .restart(restart)
);

// File: tb/tb_lcd_row_scanner.sv
module tb_lcd_row_scanner;
  localparam int NO = 60;
  localparam int D  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mux_sel;
  logic col_only, blank, set_all, sync_req, ext_frame_in;
  logic [NO-1:0] mem_data;
  logic [2:0] mem_addr, row_sel;
  logic frame_out;
  logic [2*NO-1:0] drv_code;
  logic [NO-1:0] mem [8];

  assign mem_data = mem[mem_addr];

  lcd_row_scanner #(.NUM_OUT(NO), .ROW_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .col_only(col_only),
    .blank(blank), .set_all(set_all), .sync_req(sync_req),
    .ext_frame_in(ext_frame_in), .mem_data(mem_data), .mem_addr(mem_addr),
    .row_sel(row_sel), .frame_out(frame_out), .drv_code(drv_code)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errs = 0;
  bit done = 0;
  int cur_n = 8;
  bit cur_col = 0;
  bit mon_en = 0;

  typedef struct { int row; bit pol; int gap; } exp_t;
  exp_t q[$];
  logic [2:0] prev_row = '0;
  logic prev_pol = 1'b0;
  int last_cyc = 0;

  function automatic logic [2*NO-1:0] exp_drv(int n, bit colo, int row, bit pol,
                                               logic [NO-1:0] word, bit blk, bit st);
    logic [2*NO-1:0] v;
    logic [1:0] c;
    bit on;
    for (int k = 0; k < NO; k++) begin
      if (!colo && k < n) c = (k == row) ? (pol ? 2'b00 : 2'b11) : (pol ? 2'b10 : 2'b01);
      else begin
        on = !blk && (st || word[colo ? k : k - n]);
        c  = on ? (pol ? 2'b11 : 2'b00) : (pol ? 2'b01 : 2'b10);
      end
      v[2*k +: 2] = c;
    end
    return v;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(int row, bit pol, int gap);
    exp_t e;
    e.row = row; e.pol = pol; e.gap = gap;
    q.push_back(e);
  endtask

  task automatic scan(int n, bit pol0, int count, bit first_gap, bit toggle);
    bit p = pol0;
    for (int i = 1; i <= count; i++) begin
      int r = i % n;
      if (r == 0 && toggle) p = ~p;
      push(r, p, (i == 1 && !first_gap) ? 0 : D);
    end
  endtask

  task automatic wait_q();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic pulse_sync();
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
  endtask

  // Scoreboard monitor: pops one expected item per row/polarity change
  always @(posedge clk) begin
    exp_t e;
    #3;
    if (rst_n && (row_sel !== prev_row || frame_out !== prev_pol)) begin
      if (mon_en) begin
        if (q.size() == 0) begin
          checks++; errs++;
          $display("FAIL R1 unexpected row change: actual row %0d expected none", row_sel);
        end else begin
          e = q.pop_front();
          chk("R1 row order", 128'(row_sel), 128'(e.row));
          chk(cur_col ? "R6 polarity" : "R5 polarity", 128'(frame_out), 128'(e.pol));
          if (e.gap != 0) chk("R1 row period", 128'(cyc - last_cyc), 128'(e.gap));
          chk(cur_col ? "R3 pin map" : "R2 R4 pin map", 128'(drv_code),
              128'(exp_drv(cur_n, cur_col, e.row, e.pol, mem[e.row], 0, 0)));
        end
      end
      prev_row = row_sel;
      prev_pol = frame_out;
      last_cyc = cyc;
    end
  end

  initial begin
    logic [NO-1:0] keep;
    bit p;
    mux_sel = 2'b10; col_only = 0; blank = 0; set_all = 0; sync_req = 0; ext_frame_in = 0;
    for (int r = 0; r < 8; r++) mem[r] = 60'hC35A96F0E1D7B24 ^ {15{4'(r + 1)}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 codes after reset", 128'(drv_code), 128'(exp_drv(8, 0, 0, 0, '0, 0, 0)));
    chk("R10 frame after reset", 128'(frame_out), 128'(0));
    chk("R10 row after reset", 128'(row_sel), 128'(0));
    chk("R9 fetch address", 128'(mem_addr), 128'(1));

    // 8 rows, two frames
    scan(8, 0, 16, 0, 1);
    mon_en = 1; wait_q(); mon_en = 0;

    // memory change during a row
    keep = mem[0];
    mem[0] = ~keep;
    @(negedge clk);
    chk("R9 latch holds during row", 128'(drv_code), 128'(exp_drv(8, 0, 0, 0, keep, 0, 0)));
    mem[0] = keep;

    // blank / set
    blank = 1; @(negedge clk);
    chk("R7 blank", 128'(drv_code), 128'(exp_drv(8, 0, 0, 0, mem[0], 1, 0)));
    set_all = 1; @(negedge clk);
    chk("R7 blank over set", 128'(drv_code), 128'(exp_drv(8, 0, 0, 0, mem[0], 1, 1)));
    blank = 0; @(negedge clk);
    chk("R7 set", 128'(drv_code), 128'(exp_drv(8, 0, 0, 0, mem[0], 0, 1)));
    set_all = 0; @(negedge clk);
    chk("R7 data restored", 128'(drv_code), 128'(exp_drv(8, 0, 0, 0, mem[0], 0, 0)));

    // resync mid-frame
    while (row_sel != 3'd3) @(negedge clk);
    p = frame_out;
    pulse_sync();
    chk("R8 row after sync", 128'(row_sel), 128'(0));
    chk("R8 polarity kept", 128'(frame_out), 128'(p));
    chk("R8 codes after sync", 128'(drv_code), 128'(exp_drv(8, 0, 0, p, mem[0], 0, 0)));
    scan(8, p, 8, 1, 1);
    mon_en = 1; wait_q(); mon_en = 0;

    // 4 rows
    mux_sel = 2'b01; cur_n = 4;
    pulse_sync();
    p = frame_out;
    chk("R2 map with 4 rows", 128'(drv_code), 128'(exp_drv(4, 0, 0, p, mem[0], 0, 0)));
    scan(4, p, 8, 0, 1);
    mon_en = 1; wait_q(); mon_en = 0;

    // 2 rows
    mux_sel = 2'b00; cur_n = 2;
    pulse_sync();
    p = frame_out;
    chk("R2 map with 2 rows", 128'(drv_code), 128'(exp_drv(2, 0, 0, p, mem[0], 0, 0)));
    scan(2, p, 6, 0, 1);
    mon_en = 1; wait_q(); mon_en = 0;

    // column-only, 4 rows, external frame
    mux_sel = 2'b01; cur_n = 4; cur_col = 1;
    p = ~frame_out;
    col_only = 1; ext_frame_in = p;
    @(negedge clk);
    chk("R6 restart row", 128'(row_sel), 128'(0));
    chk("R6 polarity from input", 128'(frame_out), 128'(p));
    chk("R3 all columns", 128'(drv_code), 128'(exp_drv(4, 1, 0, p, mem[0], 0, 0)));
    scan(4, p, 6, 1, 0);
    mon_en = 1; wait_q();
    push(0, ~p, 0);
    ext_frame_in = ~p;
    wait_q();
    push(1, ~p, D);
    wait_q();
    mon_en = 0;

    // column-only, 8 rows: still all columns, no toggle at wrap
    mux_sel = 2'b10; cur_n = 8;
    pulse_sync();
    p = frame_out;
    scan(8, p, 9, 0, 0);
    mon_en = 1; wait_q(); mon_en = 0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end
endmodule